// File: doc/BRIEF.md
# Sleep State Power Controller

This block follows the platform through its power states: working, powered-on suspend, suspend to RAM, suspend to disk and soft off. It drives four active-low power-plane cut controls whose assertion deepens with the state, an active-low suspend warning, an active-low bus reset and a one-cycle event pulse toward software. All inputs are taken as already synchronous to `clk`. A slow-clock period is marked by a one-cycle `slow_tick` pulse.

Software asks for a sleep state with `sleep_req` and a state code. The block then raises the suspend warning, waits a fixed number of cycles, and only after that asserts the plane cuts. A wake starts by releasing every cut. The warning is held for a further fixed number of cycles and then released. Three paths reach soft off without the prelude. A low thermal trip input takes effect at once. Holding the power button for a set number of slow ticks also forces soft off, and after that only the button can wake the system. The third path is a power-good loss that lasts long enough.

Top module: `pwr_state_ctrl`

## Requirements
- R1: Plane cuts are nested by depth. In powered-on suspend only cut1 is low. In suspend to RAM cut1 and cut3 are low. In suspend to disk cut1, cut3 and cut4 are low. In soft off all four are low. In every other state all four are high. The sleep state codes on `sleep_type` are 1 for powered-on suspend, 3 for suspend to RAM, 4 for suspend to disk and 5 for soft off.
- R2: In the working state, `sleep_req` with a valid code drives `susp_warn_n` low on the next cycle. The cuts change to that state's pattern PREP_CYC cycles later. Invalid codes (0, 2, 6, 7) are ignored, and so is any request made outside the working state.
- R3: A wake releases all cuts on the cycle after the wake event. `susp_warn_n` returns high EXIT_CYC cycles after the cuts are released.
- R4: A power button press (a high-to-low edge on `pwr_btn_n`) in the working state gives one `sw_event` pulse on the next cycle and does not change any cut. A press in any sleep state is a wake event.
- R5: A low `therm_trip_n` forces soft off on the next cycle from any state, with no prelude. All cuts go low and `susp_warn_n` goes low together with them.
- R6: While the button is held, OVR_TICKS slow ticks force soft off. The cuts go low on the second cycle after the cycle of the last tick. Releasing the button clears the tick count.
- R7: After a button-hold override, ring-indicate cannot wake the system. A button press still wakes it, and the wake clears this lock.
- R8: `ring_n` low while `ring_wake_en` is 1, in a sleep state, is a wake event. With `ring_wake_en` at 0, `ring_n` has no effect.
- R9: `bus_rst_n` is high only if, on the previous cycle, `pwr_good` was high and the block was either working or in the entry prelude. It is low on the cycle after `pwr_good` falls.
- R10: While working, `pwr_good` low across PG_TICKS slow ticks forces soft off. A shorter low pulse leaves the state unchanged.
- R11: After reset the block is in the working state: all cuts high, `susp_warn_n` high, `sw_event` low. `bus_rst_n` is low during reset.
- R12: While `therm_trip_n` is low, no wake event leaves soft off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset of the always-on logic |
| slow_tick | input | 1 | One-cycle pulse marking one slow-clock period |
| pwr_btn_n | input | 1 | Power button, low while pressed |
| therm_trip_n | input | 1 | Thermal trip, low when tripped |
| ring_n | input | 1 | Ring indicate, low when ringing |
| ring_wake_en | input | 1 | Ring-indicate wake enable, held in the always-on domain |
| sleep_req | input | 1 | Software sleep request strobe |
| sleep_type | input | 3 | Requested sleep state code |
| pwr_good | input | 1 | Core power good |
| plane_cut1_n | output | 1 | Shallowest plane cut, active low |
| plane_cut3_n | output | 1 | RAM-suspend plane cut, active low |
| plane_cut4_n | output | 1 | Disk-suspend plane cut, active low |
| plane_cut5_n | output | 1 | Soft-off plane cut, active low |
| susp_warn_n | output | 1 | Suspend warning, active low |
| bus_rst_n | output | 1 | Bus reset, active low |
| sw_event | output | 1 | One-cycle software event pulse |

## Verification
Software entries are tried with random valid and invalid codes. Checking the cut pattern separates the four depths, and checking the lead and lag cycle counts of the warning against the cut edges exposes off-by-one errors in the prelude and the resume. Wakes are driven by either the button or ring-indicate, with the enable and the override lock both set and clear, to show which source is masked. Directed cases cover button holds that fall one tick short, a release that must clear the count, power-good pulses below and at the filter length, and thermal trips from both the working state and a sleep state. The thermal cases include a button press made while the trip is still low.

// File: rtl/pwr_pkg.sv
package pwr_pkg;

    localparam int NUM_CUTS = 4;

    typedef enum logic [2:0] {
        ST_ON     = 3'd0,
        ST_S1M    = 3'd1,
        ST_PREP   = 3'd2,
        ST_S3     = 3'd3,
        ST_S4     = 3'd4,
        ST_S5     = 3'd5,
        ST_RESUME = 3'd6
    } pwr_state_e;

    // Sleep states carry their own code as encoding, so a request code maps straight to a state.
    function automatic logic valid_target(input logic [2:0] code);
        return (code == 3'd1) || (code == 3'd3) || (code == 3'd4) || (code == 3'd5);
    endfunction

    function automatic logic is_sleep(input pwr_state_e s);
        return valid_target(s);
    endfunction

    // Minimum sleep code at which cut number g is asserted.
    function automatic logic [2:0] cut_level(input int g);
        case (g)
            0:       return 3'd1;
            1:       return 3'd3;
            2:       return 3'd4;
            default: return 3'd5;
        endcase
    endfunction

endpackage

// File: rtl/tick_hold.sv
module tick_hold #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic tick,
    output logic hit
);
    localparam int CW = $clog2(LIMIT + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          done;
        logic          hit;
    } hold_t;

    hold_t q, d;

    always_comb begin
        d     = q;
        d.hit = 1'b0;
        if (!active) begin
            d.cnt  = '0;
            d.done = 1'b0;
        end else if (tick && !q.done) begin
            if (q.cnt == CW'(LIMIT - 1)) begin
                d.cnt  = '0;
                d.done = 1'b1;
                d.hit  = 1'b1;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign hit = q.hit;
endmodule

// File: rtl/sleep_decode.sv
module sleep_decode
    import pwr_pkg::*;
(
    input  pwr_state_e           state,
    output logic [NUM_CUTS-1:0]  cut
);
    for (genvar g = 0; g < NUM_CUTS; g++) begin : g_cut
        assign cut[g] = is_sleep(state) && (3'(state) >= cut_level(g));
    end
endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm
    import pwr_pkg::*;
#(
    parameter int PREP_CYC = 8,
    parameter int EXIT_CYC = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 btn_n,
    input  logic                 therm_n,
    input  logic                 ring_n,
    input  logic                 ring_en,
    input  logic                 req,
    input  logic [2:0]           req_type,
    input  logic                 pwr_good,
    input  logic                 ovr_hit,
    input  logic                 pg_hit,
    output logic [NUM_CUTS-1:0]  cut_n,
    output logic                 susp_n,
    output logic                 bus_rst_n,
    output logic                 sw_event,
    output logic                 working
);
    localparam int MAXC = (PREP_CYC > EXIT_CYC) ? PREP_CYC : EXIT_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    typedef struct packed {
        pwr_state_e          state;
        logic [CW-1:0]       cnt;
        pwr_state_e          tgt;
        logic                lock;
        logic                btn_prev;
        logic                event_p;
        logic [NUM_CUTS-1:0] cut_n;
        logic                susp_n;
        logic                bus_rst_n;
    } fsm_t;

    fsm_t q, d;
    logic [NUM_CUTS-1:0] cut_next;
    logic press, in_sleep, wake, work_q;

    sleep_decode u_dec (
        .state (d.state),
        .cut   (cut_next)
    );

    always_comb begin
        press    = q.btn_prev & ~btn_n;
        in_sleep = is_sleep(q.state);
        work_q   = (q.state == ST_ON) || (q.state == ST_PREP) || (q.state == ST_RESUME);
        wake     = in_sleep & therm_n & (press | (ring_en & ~ring_n & ~q.lock));

        d          = q;
        d.event_p  = 1'b0;
        d.btn_prev = btn_n;

        if (ovr_hit) begin
            d.state = ST_S5;
            d.lock  = 1'b1;
        end else if (!therm_n) begin
            d.state = ST_S5;
        end else if (pg_hit && work_q) begin
            d.state = ST_S5;
        end else begin
            case (q.state)
                ST_ON: begin
                    if (press) begin
                        d.event_p = 1'b1;
                    end
                    if (req && valid_target(req_type)) begin
                        d.state = ST_PREP;
                        d.tgt   = pwr_state_e'(req_type);
                        d.cnt   = '0;
                    end
                end
                ST_PREP: begin
                    if (q.cnt == CW'(PREP_CYC - 1)) begin
                        d.state = q.tgt;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                ST_RESUME: begin
                    if (q.cnt == CW'(EXIT_CYC - 1)) begin
                        d.state = ST_ON;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                default: begin
                    if (wake) begin
                        d.state = ST_RESUME;
                        d.cnt   = '0;
                        d.lock  = 1'b0;
                    end
                end
            endcase
        end

        d.cut_n     = ~cut_next;
        d.susp_n    = (d.state == ST_ON);
        d.bus_rst_n = pwr_good && ((d.state == ST_ON) || (d.state == ST_PREP));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state     <= ST_ON;
            q.cnt       <= '0;
            q.tgt       <= ST_ON;
            q.lock      <= 1'b0;
            q.btn_prev  <= 1'b1;
            q.event_p   <= 1'b0;
            q.cut_n     <= '1;
            q.susp_n    <= 1'b1;
            q.bus_rst_n <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign cut_n     = q.cut_n;
    assign susp_n    = q.susp_n;
    assign bus_rst_n = q.bus_rst_n;
    assign sw_event  = q.event_p;
    assign working   = work_q;
endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
    import pwr_pkg::*;
#(
    parameter int PREP_CYC  = 8,
    parameter int EXIT_CYC  = 8,
    parameter int OVR_TICKS = 131072,
    parameter int PG_TICKS  = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       slow_tick,
    input  logic       pwr_btn_n,
    input  logic       therm_trip_n,
    input  logic       ring_n,
    input  logic       ring_wake_en,
    input  logic       sleep_req,
    input  logic [2:0] sleep_type,
    input  logic       pwr_good,
    output logic       plane_cut1_n,
    output logic       plane_cut3_n,
    output logic       plane_cut4_n,
    output logic       plane_cut5_n,
    output logic       susp_warn_n,
    output logic       bus_rst_n,
    output logic       sw_event
);
    logic ovr_hit, pg_hit, working;
    logic [NUM_CUTS-1:0] cut_n;

    tick_hold #(.LIMIT(OVR_TICKS)) u_btn_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (~pwr_btn_n),
        .tick   (slow_tick),
        .hit    (ovr_hit)
    );

    tick_hold #(.LIMIT(PG_TICKS)) u_pg_filt (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (~pwr_good & working),
        .tick   (slow_tick),
        .hit    (pg_hit)
    );

    pwr_fsm #(.PREP_CYC(PREP_CYC), .EXIT_CYC(EXIT_CYC)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .btn_n     (pwr_btn_n),
        .therm_n   (therm_trip_n),
        .ring_n    (ring_n),
        .ring_en   (ring_wake_en),
        .req       (sleep_req),
        .req_type  (sleep_type),
        .pwr_good  (pwr_good),
        .ovr_hit   (ovr_hit),
        .pg_hit    (pg_hit),
        .cut_n     (cut_n),
        .susp_n    (susp_warn_n),
        .bus_rst_n (bus_rst_n),
        .sw_event  (sw_event),
        .working   (working)
    );

    assign plane_cut1_n = cut_n[0];
    assign plane_cut3_n = cut_n[1];
    assign plane_cut4_n = cut_n[2];
    assign plane_cut5_n = cut_n[3];
endmodule

// File: rtl/pwr_state_ctrl_chk.sv
module pwr_state_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic therm_trip_n,
    input logic pwr_good,
    input logic plane_cut1_n,
    input logic plane_cut3_n,
    input logic plane_cut4_n,
    input logic plane_cut5_n,
    input logic susp_warn_n,
    input logic bus_rst_n,
    input logic sw_event
);
    logic [3:0] on_vec;
    assign on_vec = ~{plane_cut5_n, plane_cut4_n, plane_cut3_n, plane_cut1_n};

    a_r1_nested: assert property (@(posedge clk) disable iff (!rst_n)
        ((on_vec & (on_vec + 4'd1)) == 4'd0));

    a_r2_warn_covers: assert property (@(posedge clk) disable iff (!rst_n)
        (on_vec != 4'd0) |-> !susp_warn_n);

    a_r3_warn_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(susp_warn_n) |-> (on_vec == 4'd0) && ($past(on_vec) == 4'd0));

    a_r4_event_from_on: assert property (@(posedge clk) disable iff (!rst_n)
        sw_event |-> $past(susp_warn_n));

    a_r5_thermal_off: assert property (@(posedge clk) disable iff (!rst_n)
        !therm_trip_n |=> (on_vec == 4'hF));

    a_r9_bus_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> !bus_rst_n);
endmodule

bind pwr_state_ctrl pwr_state_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .therm_trip_n (therm_trip_n),
    .pwr_good     (pwr_good),
    .plane_cut1_n (plane_cut1_n),
    .plane_cut3_n (plane_cut3_n),
    .plane_cut4_n (plane_cut4_n),
    .plane_cut5_n (plane_cut5_n),
    .susp_warn_n  (susp_warn_n),
    .bus_rst_n    (bus_rst_n),
    .sw_event     (sw_event)
);

// File: tb/sim_pwr_state_ctrl.sv
module sim_pwr_state_ctrl;
    localparam int PREP = 4;
    localparam int EXIT = 3;
    localparam int OVR  = 5;
    localparam int PGT  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic slow_tick = 1'b0;
    logic pwr_btn_n = 1'b1;
    logic therm_trip_n = 1'b1;
    logic ring_n = 1'b1;
    logic ring_wake_en = 1'b0;
    logic sleep_req = 1'b0;
    logic [2:0] sleep_type = 3'd0;
    logic pwr_good = 1'b1;
    logic plane_cut1_n, plane_cut3_n, plane_cut4_n, plane_cut5_n;
    logic susp_warn_n, bus_rst_n, sw_event;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    pwr_state_ctrl #(.PREP_CYC(PREP), .EXIT_CYC(EXIT), .OVR_TICKS(OVR), .PG_TICKS(PGT)) u0 (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .pwr_btn_n(pwr_btn_n),
        .therm_trip_n(therm_trip_n), .ring_n(ring_n), .ring_wake_en(ring_wake_en),
        .sleep_req(sleep_req), .sleep_type(sleep_type), .pwr_good(pwr_good),
        .plane_cut1_n(plane_cut1_n), .plane_cut3_n(plane_cut3_n),
        .plane_cut4_n(plane_cut4_n), .plane_cut5_n(plane_cut5_n),
        .susp_warn_n(susp_warn_n), .bus_rst_n(bus_rst_n), .sw_event(sw_event)
    );

    function automatic logic [3:0] cuts();
        return {plane_cut5_n, plane_cut4_n, plane_cut3_n, plane_cut1_n};
    endfunction

    // Expected {cut5,cut4,cut3,cut1} for a sleep code, per R1.
    function automatic logic [3:0] exp_cut(input logic [2:0] code);
        case (code)
            3'd1:    return 4'b1110;
            3'd3:    return 4'b1100;
            3'd4:    return 4'b1000;
            3'd5:    return 4'b0000;
            default: return 4'b1111;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %0h exp %0h", tag, got, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick_slow();
        slow_tick = 1'b1;
        @(negedge clk);
        slow_tick = 1'b0;
    endtask

    task automatic enter(input logic [2:0] code);
        sleep_req = 1'b1;
        sleep_type = code;
        @(negedge clk);
        sleep_req = 1'b0;
        chk("R2 warn low", 8'(susp_warn_n), 8'd0);
        chk("R2 cuts wait", 8'(cuts()), 8'hF);
        cyc(PREP - 1);
        chk("R2 cuts still wait", 8'(cuts()), 8'hF);
        cyc(1);
        chk("R1 cut pattern", 8'(cuts()), 8'(exp_cut(code)));
        chk("R9 bus reset in sleep", 8'(bus_rst_n), 8'd0);
    endtask

    task automatic wake(input logic by_ring);
        if (by_ring) begin
            ring_wake_en = 1'b1;
            ring_n = 1'b0;
        end else begin
            pwr_btn_n = 1'b0;
        end
        @(negedge clk);
        ring_n = 1'b1;
        ring_wake_en = 1'b0;
        pwr_btn_n = 1'b1;
        chk(by_ring ? "R8 ring wake" : "R3 button wake", 8'(cuts()), 8'hF);
        chk("R3 warn held", 8'(susp_warn_n), 8'd0);
        cyc(EXIT - 1);
        chk("R3 warn still held", 8'(susp_warn_n), 8'd0);
        cyc(1);
        chk("R3 warn released", 8'(susp_warn_n), 8'd1);
        chk("R9 bus reset released", 8'(bus_rst_n), 8'd1);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_fail++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        logic [2:0] code;
        void'($urandom(32'd20240611));
        cyc(3);
        chk("R11 bus reset in reset", 8'(bus_rst_n), 8'd0);
        chk("R11 cuts in reset", 8'(cuts()), 8'hF);
        rst_n = 1'b1;
        cyc(2);
        chk("R11 cuts", 8'(cuts()), 8'hF);
        chk("R11 warn", 8'(susp_warn_n), 8'd1);
        chk("R11 event", 8'(sw_event), 8'd0);
        chk("R9 bus reset up", 8'(bus_rst_n), 8'd1);

        // R4: button press in working state
        pwr_btn_n = 1'b0;
        @(negedge clk);
        chk("R4 event pulse", 8'(sw_event), 8'd1);
        chk("R4 no cut change", 8'(cuts()), 8'hF);
        @(negedge clk);
        chk("R4 pulse one cycle", 8'(sw_event), 8'd0);
        pwr_btn_n = 1'b1;
        cyc(2);

        // R2: invalid code ignored
        sleep_req = 1'b1;
        sleep_type = 3'd2;
        @(negedge clk);
        sleep_req = 1'b0;
        chk("R2 invalid ignored", 8'(susp_warn_n), 8'd1);
        cyc(PREP + 1);
        chk("R2 invalid no cuts", 8'(cuts()), 8'hF);

        // R8: ring without enable is ignored, then with enable wakes; R2 request outside working ignored
        enter(3'd3);
        ring_n = 1'b0;
        cyc(3);
        chk("R8 ring disabled", 8'(cuts()), 8'(exp_cut(3'd3)));
        ring_n = 1'b1;
        sleep_req = 1'b1;
        sleep_type = 3'd5;
        @(negedge clk);
        sleep_req = 1'b0;
        cyc(PREP + 2);
        chk("R2 request in sleep ignored", 8'(cuts()), 8'(exp_cut(3'd3)));
        wake(1'b1);

        // R5 and R12: thermal trip from a sleep state, wake blocked while tripped
        enter(3'd4);
        therm_trip_n = 1'b0;
        @(negedge clk);
        chk("R5 thermal from sleep", 8'(cuts()), 8'h0);
        pwr_btn_n = 1'b0;
        cyc(2);
        chk("R12 no wake while tripped", 8'(cuts()), 8'h0);
        pwr_btn_n = 1'b1;
        therm_trip_n = 1'b1;
        cyc(1);
        wake(1'b0);

        // R5: thermal trip from working skips the prelude
        therm_trip_n = 1'b0;
        @(negedge clk);
        chk("R5 thermal from working", 8'(cuts()), 8'h0);
        chk("R5 warn with cuts", 8'(susp_warn_n), 8'd0);
        therm_trip_n = 1'b1;
        cyc(1);
        wake(1'b1);

        // R6: hold short of the limit, release clears, then full hold overrides
        pwr_btn_n = 1'b0;
        cyc(1);
        repeat (OVR - 1) tick_slow();
        cyc(2);
        chk("R6 short hold", 8'(cuts()), 8'hF);
        pwr_btn_n = 1'b1;
        cyc(1);
        pwr_btn_n = 1'b0;
        cyc(1);
        repeat (OVR - 1) tick_slow();
        cyc(2);
        chk("R6 release cleared count", 8'(cuts()), 8'hF);
        tick_slow();
        chk("R6 not before second cycle", 8'(cuts()), 8'hF);
        @(negedge clk);
        chk("R6 override to soft off", 8'(cuts()), 8'h0);
        pwr_btn_n = 1'b1;
        cyc(2);
        chk("R6 release does not wake", 8'(cuts()), 8'h0);

        // R7: ring blocked after override, button wakes and clears lock
        ring_wake_en = 1'b1;
        ring_n = 1'b0;
        cyc(3);
        chk("R7 ring locked out", 8'(cuts()), 8'h0);
        ring_n = 1'b1;
        ring_wake_en = 1'b0;
        cyc(1);
        wake(1'b0);
        enter(3'd1);
        wake(1'b1);

        // R10: short power-good dip ignored, long one forces soft off
        pwr_good = 1'b0;
        @(negedge clk);
        chk("R9 bus reset on power loss", 8'(bus_rst_n), 8'd0);
        repeat (PGT - 1) tick_slow();
        pwr_good = 1'b1;
        cyc(2);
        chk("R10 short dip ignored", 8'(cuts()), 8'hF);
        chk("R9 bus reset back", 8'(bus_rst_n), 8'd1);
        pwr_good = 1'b0;
        cyc(1);
        repeat (PGT) tick_slow();
        @(negedge clk);
        chk("R10 long dip to soft off", 8'(cuts()), 8'h0);
        pwr_good = 1'b1;
        cyc(1);
        wake(1'b0);

        // Random entries and wakes
        for (int i = 0; i < 40; i++) begin
            if ($urandom_range(0, 3) == 0) begin
                code = 3'(($urandom_range(0, 3) == 0) ? 0 : (($urandom_range(0, 1) == 0) ? 2 : 6 + $urandom_range(0, 1)));
                sleep_req = 1'b1;
                sleep_type = code;
                @(negedge clk);
                sleep_req = 1'b0;
                chk("R2 random invalid", 8'(susp_warn_n), 8'd1);
                cyc(PREP + 1);
                chk("R2 random invalid cuts", 8'(cuts()), 8'hF);
            end else begin
                case ($urandom_range(0, 3))
                    0:       code = 3'd1;
                    1:       code = 3'd3;
                    2:       code = 3'd4;
                    default: code = 3'd5;
                endcase
                enter(code);
                cyc($urandom_range(0, 5));
                chk("R1 random hold", 8'(cuts()), 8'(exp_cut(code)));
                wake(1'($urandom_range(0, 1)));
            end
            cyc($urandom_range(0, 3));
        end

        summary();
    end
endmodule